// File: doc/BRIEF.md
# Monochrome Raster Timing and Pixel Engine

This block drives a fixed-format one-bit-per-pixel display straight off the system clock, one dot per clock. A horizontal dot counter and a vertical line counter walk a 704-dot by 370-line raster. Of that raster, 512 dots by 342 lines are visible. Decoding the counters gives active-low blank and sync strobes for both axes. It also gives a single-clock frame pulse that the system can use as its periodic (about 60 Hz) interrupt.

Picture data lives in shared main memory. The block fetches each visible line as a run of 16-bit words, starting from a programmable base byte address. A typical base is 0x9F9A80, just below the top of a 10 MB memory. Words are requested over a valid/ready handshake and returned on a separate read-valid strobe, one word in flight at a time. A one-word holding buffer feeds a shifter that emits one bit per dot, most significant bit first. Back-pressure rules: `fetch_valid` with `fetch_addr` stays asserted and unchanged until `fetch_ready` is seen high on a clock edge. The only exception is the clock after the last visible dot of a line, where the request is withdrawn and retargeted to the next line. The return path has no ready: each `rd_valid` pulse is accepted if a request was granted and not yet answered.

Top module: `mono_raster_timer`

## Requirements
- R1: `hcount` runs 0 to H_TOTAL-1 (704) and wraps to 0; `hblank_n` is low exactly for dots H_ACTIVE (512) and above.
- R2: `vcount` advances when `hcount` wraps, runs 0 to V_TOTAL-1 (370) and wraps from 369 to 0; `vblank_n` is low exactly for lines V_ACTIVE (342) and above.
- R3: `hsync_n` is low for H_SYNC (32) dots, starting H_FP (14) dots after the last visible dot, and only inside horizontal blanking.
- R4: `vsync_n` is low for V_SYNC (4) lines, starting V_FP (0) lines after the last visible line, and only inside vertical blanking.
- R5: `frame_pulse` is high for exactly one clock per frame, at dot 0 of the first vertical sync line.
- R6: During reset the raster sits at dot H_ACTIVE of line V_TOTAL-1; both blanks are low, both syncs high, and `frame_pulse`, `pixel` and `fetch_valid` are low.
- R7: Word w of visible line r is fetched from byte address base + 2*(r*H_ACTIVE/16 + w), in increasing w. Line r is fetched starting in the horizontal blank of the line before it; line 0 starts in the blank of line V_TOTAL-1. `vid_base` is sampled once per frame, at the start of horizontal blanking of line V_TOTAL-1.
- R8: A raised `fetch_valid` keeps its level and `fetch_addr` until granted, except that it is withdrawn in the clock after the last visible dot; at most one granted word is outstanding.
- R9: During a visible dot, `pixel` is bit (15 - hcount mod 16) of the word fetched for that dot position (bit 15 first).
- R10: `pixel` is 0 (black) whenever `hblank_n` or `vblank_n` is low.
- R11: If the memory never grants, every visible dot is black. During the blanking of each line whose next line is visible, the request stays posted for that next line's word 0. During the blanking of other lines no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot / system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_base | input | ADDR_W | Frame buffer base byte address |
| fetch_valid | output | 1 | Word fetch request |
| fetch_ready | input | 1 | Memory grant for the request |
| fetch_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Returned word strobe |
| rd_data | input | WORD_W | Returned word |
| hblank_n | output | 1 | Horizontal blank, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vblank_n | output | 1 | Vertical blank, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 1 | Dot value, 1 white, 0 black |
| hcount | output | $clog2(H_TOTAL) | Dot counter |
| vcount | output | $clog2(V_TOTAL) | Line counter |
| frame_pulse | output | 1 | One clock per frame at vertical sync start |

## Verification
The bench builds the block with a shrunken raster: 64 visible dots in 104-dot lines, a 6-dot front porch and 8-dot sync, and 6 visible lines in a 10-line frame with 2 sync lines. This keeps the 16-bit word and all fetch rules intact. At that size a whole frame is about a thousand clocks. The bench can then compare every dot of several complete frames against a model built from the requirements. These frames cover counter wraps, the frame pulse, a base change taking effect at the next frame, a slow and stalling memory, and a memory that never grants.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef struct packed {
    logic hblank_n;
    logic hsync_n;
    logic vblank_n;
    logic vsync_n;
  } sync_t;

  // true when val lies in [lo, lo+len)
  function automatic logic in_span(input int val, input int lo, input int len);
    return (val >= lo) && (val < lo + len);
  endfunction

endpackage

// File: rtl/rt_counters.sv
module rt_counters #(
  parameter int H_TOTAL = 704,
  parameter int V_TOTAL = 370,
  parameter int H_RST   = 512,
  parameter int V_RST   = 369,
  parameter int HW      = 10,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v,
  output logic [HW-1:0] next_h,
  output logic [VW-1:0] next_v
);

  logic h_end, v_end;

  assign h_end = (h == HW'(H_TOTAL - 1));
  assign v_end = (v == VW'(V_TOTAL - 1));

  always_comb begin
    next_h = h_end ? '0 : h + 1'b1;
    next_v = v;
    if (h_end) next_v = v_end ? '0 : v + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h <= HW'(H_RST);
      v <= VW'(V_RST);
    end else begin
      h <= next_h;
      v <= next_v;
    end
  end

endmodule

// File: rtl/rt_fetch.sv
module rt_fetch #(
  parameter int H_ACTIVE = 512,
  parameter int V_ACTIVE = 342,
  parameter int V_TOTAL  = 370,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 24,
  parameter int HW       = 10,
  parameter int VW       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     h,
  input  logic [VW-1:0]     v,
  input  logic [ADDR_W-1:0] base,
  input  logic              load,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] word_out
);

  localparam int WPL = H_ACTIVE / WORD_W;
  localparam int FW  = $clog2(WPL + 1);
  localparam int BPW = WORD_W / 8;

  logic              init, grant, accept;
  logic [VW-1:0]     frow, nrow;
  logic [FW-1:0]     fidx;
  logic              on, pending, drop, full;
  logic [ADDR_W-1:0] base_q;
  logic [WORD_W-1:0] hold;

  // first blanked dot of every line retargets the fetcher to the next line
  assign init   = (h == HW'(H_ACTIVE));
  assign nrow   = (v == VW'(V_TOTAL - 1)) ? '0 : v + 1'b1;

  assign fetch_valid = on && !full && !pending && (fidx < FW'(WPL)) && !init;
  assign grant       = fetch_valid && fetch_ready;
  assign accept      = rd_valid && pending && !drop && !init;
  assign fetch_addr  = base_q +
                       (ADDR_W'(frow) * ADDR_W'(WPL) + ADDR_W'(fidx)) * ADDR_W'(BPW);
  assign word_out    = full ? hold : (accept ? rd_data : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frow    <= '0;
      fidx    <= '0;
      on      <= 1'b1;
      base_q  <= '0;
      pending <= 1'b0;
      drop    <= 1'b0;
      full    <= 1'b0;
      hold    <= '0;
    end else begin
      if (grant)         pending <= 1'b1;
      else if (rd_valid) pending <= 1'b0;

      if (init) begin
        frow <= nrow;
        fidx <= '0;
        on   <= (nrow < VW'(V_ACTIVE));
        full <= 1'b0;
        // a word still in flight belongs to the old line
        drop <= pending && !rd_valid;
        if (nrow == '0) base_q <= base;
      end else begin
        if (grant)    fidx <= fidx + 1'b1;
        if (rd_valid) drop <= 1'b0;
        if (load) begin
          full <= 1'b0;
        end else if (accept) begin
          full <= 1'b1;
          hold <= rd_data;
        end
      end
    end
  end

endmodule

// File: rtl/rt_shifter.sv
module rt_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic              bit_out
);

  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg <= '0;
    else if (load) sreg <= word_in;
    else           sreg <= {sreg[WORD_W-2:0], 1'b0};
  end

  assign bit_out = sreg[WORD_W-1];

endmodule

// File: rtl/mono_raster_timer.sv
module mono_raster_timer #(
  parameter int H_ACTIVE = 512,
  parameter int H_TOTAL  = 704,
  parameter int H_FP     = 14,
  parameter int H_SYNC   = 32,
  parameter int V_ACTIVE = 342,
  parameter int V_TOTAL  = 370,
  parameter int V_FP     = 0,
  parameter int V_SYNC   = 4,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           vid_base,
  output logic                        fetch_valid,
  input  logic                        fetch_ready,
  output logic [ADDR_W-1:0]           fetch_addr,
  input  logic                        rd_valid,
  input  logic [WORD_W-1:0]           rd_data,
  output logic                        hblank_n,
  output logic                        hsync_n,
  output logic                        vblank_n,
  output logic                        vsync_n,
  output logic                        pixel,
  output logic [$clog2(H_TOTAL)-1:0]  hcount,
  output logic [$clog2(V_TOTAL)-1:0]  vcount,
  output logic                        frame_pulse
);

  localparam int HW       = $clog2(H_TOTAL);
  localparam int VW       = $clog2(V_TOTAL);
  localparam int HS_START = H_ACTIVE + H_FP;
  localparam int VS_START = V_ACTIVE + V_FP;

  logic [HW-1:0]     h, nh;
  logic [VW-1:0]     v, nv;
  logic              load, raw_bit;
  logic [WORD_W-1:0] word;
  rt_pkg::sync_t     st;

  rt_counters #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .H_RST(H_ACTIVE), .V_RST(V_TOTAL - 1),
    .HW(HW), .VW(VW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .h(h), .v(v), .next_h(nh), .next_v(nv)
  );

  // a new word enters the shifter on the edge that starts its first dot
  assign load = (int'(nh) < H_ACTIVE) && (int'(nv) < V_ACTIVE) &&
                ((int'(nh) % WORD_W) == 0);

  rt_fetch #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .HW(HW), .VW(VW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .h(h), .v(v), .base(vid_base), .load(load),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .word_out(word)
  );

  rt_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(word), .bit_out(raw_bit)
  );

  always_comb begin
    st.hblank_n = !rt_pkg::in_span(int'(h), H_ACTIVE, H_TOTAL - H_ACTIVE);
    st.hsync_n  = !rt_pkg::in_span(int'(h), HS_START, H_SYNC);
    st.vblank_n = !rt_pkg::in_span(int'(v), V_ACTIVE, V_TOTAL - V_ACTIVE);
    st.vsync_n  = !rt_pkg::in_span(int'(v), VS_START, V_SYNC);
  end

  assign hblank_n    = st.hblank_n;
  assign hsync_n     = st.hsync_n;
  assign vblank_n    = st.vblank_n;
  assign vsync_n     = st.vsync_n;
  assign pixel       = raw_bit && st.hblank_n && st.vblank_n;
  assign hcount      = h;
  assign vcount      = v;
  assign frame_pulse = (int'(v) == VS_START) && (h == '0);

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int H_ACTIVE = 512,
  parameter int H_TOTAL  = 704,
  parameter int V_TOTAL  = 370,
  parameter int ADDR_W   = 24,
  parameter int HW       = 10,
  parameter int VW       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hblank_n,
  input logic              hsync_n,
  input logic              vblank_n,
  input logic              vsync_n,
  input logic              pixel,
  input logic              frame_pulse,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [HW-1:0]     hcount,
  input logic [VW-1:0]     vcount
);

  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcount == HW'(H_TOTAL - 1) |=> hcount == '0);

  // R2
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == HW'(H_TOTAL - 1)) && (vcount == VW'(V_TOTAL - 1)) |=> vcount == '0);

  // R3
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !hblank_n);

  // R4
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !vblank_n);

  // R5
  pulse_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (!vsync_n && hcount == '0));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready && (hcount != HW'(H_ACTIVE - 1))
      |=> fetch_valid && $stable(fetch_addr));

  // R10
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hblank_n || !vblank_n) |-> !pixel);

endmodule

bind mono_raster_timer rt_checker #(
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
  .ADDR_W(ADDR_W), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hblank_n(hblank_n), .hsync_n(hsync_n),
  .vblank_n(vblank_n), .vsync_n(vsync_n), .pixel(pixel), .frame_pulse(frame_pulse),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
  .hcount(hcount), .vcount(vcount)
);

// File: tb/sim_mono_raster_timer.sv
module sim_mono_raster_timer;

  localparam int HA = 64, HT = 104, HF = 6, HS = 8;
  localparam int VA = 6, VT = 10, VF = 0, VS = 2;
  localparam int WW = 16, AW = 24;
  localparam int WPL = HA / WW;
  localparam int FRAME = HT * VT;
  localparam int P0 = (VT - 1) * HT + HA;
  localparam int HWB = $clog2(HT), VWB = $clog2(VT);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] vid_base = 24'h9F9A80;
  logic fetch_ready = 0, rd_valid = 0;
  logic [WW-1:0] rd_data = '0;
  logic fetch_valid, hblank_n, hsync_n, vblank_n, vsync_n, pixel, frame_pulse;
  logic [AW-1:0] fetch_addr;
  logic [HWB-1:0] hcount;
  logic [VWB-1:0] vcount;

  int cyc = 0, n_chk = 0, n_err = 0;
  bit mem_on = 1, mem_stall = 0, done = 0;
  int mem_lat = 1;
  logic [AW-1:0] glog [64];
  int gn = 0;

  mono_raster_timer #(
    .H_ACTIVE(HA), .H_TOTAL(HT), .H_FP(HF), .H_SYNC(HS),
    .V_ACTIVE(VA), .V_TOTAL(VT), .V_FP(VF), .V_SYNC(VS),
    .WORD_W(WW), .ADDR_W(AW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .vid_base(vid_base),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hblank_n(hblank_n), .hsync_n(hsync_n), .vblank_n(vblank_n), .vsync_n(vsync_n),
    .pixel(pixel), .hcount(hcount), .vcount(vcount), .frame_pulse(frame_pulse)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (rst_n) cyc++;
  end

  function automatic int pos();
    return (P0 + cyc) % FRAME;
  endfunction

  function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
    return (a[15:0] * 16'd40503) ^ 16'h1357;
  endfunction

  // memory model: grant and return at falling edges
  initial begin
    bit acc = 0, busy = 0, tog = 0;
    int lat_cnt = 0;
    logic [AW-1:0] acc_addr = '0, cur_addr = '0;
    forever begin
      @(negedge clk);
      if (acc) begin busy = 1; lat_cnt = mem_lat; cur_addr = acc_addr; acc = 0; end
      if (busy && lat_cnt == 0) begin
        rd_valid = 1; rd_data = pat(cur_addr); busy = 0;
      end else begin
        rd_valid = 0;
        if (busy) lat_cnt--;
      end
      tog = !tog;
      fetch_ready = mem_on && !busy && (!mem_stall || tog);
      if (fetch_ready && fetch_valid && rst_n) begin
        acc = 1; acc_addr = fetch_addr;
        if (gn < 64) glog[gn] = fetch_addr;
        gn++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic t_reset();
    #5;
    chk(hcount == HWB'(HA), "R6 reset hcount", int'(hcount), HA);
    chk(vcount == VWB'(VT - 1), "R6 reset vcount", int'(vcount), VT - 1);
    chk({hblank_n, vblank_n} == 2'b00, "R6 reset blanks", {hblank_n, vblank_n}, 0);
    chk({hsync_n, vsync_n} == 2'b11, "R6 reset syncs", {hsync_n, vsync_n}, 3);
    chk({frame_pulse, pixel, fetch_valid} == 3'b000, "R6 reset pulse/pixel/req",
        {frame_pulse, pixel, fetch_valid}, 0);
  endtask

  // one whole frame compared dot by dot; black = memory never grants
  task automatic check_frame(input logic [AW-1:0] b_now, input logic [AW-1:0] b_next,
                             input bit black);
    int e_cnt = 0, e_hb = 0, e_vb = 0, e_hs = 0, e_vs = 0, e_pix = 0, e_req = 0;
    int n_fp = 0, e_fp = 0;
    do begin @(negedge clk); #1; end while (pos() != FRAME - 1);
    gn = 0;
    vid_base = b_next;
    for (int k = 0; k < FRAME; k++) begin
      int p, h, v, nr;
      logic [WW-1:0] w;
      logic ep;
      @(negedge clk); #1;
      p = pos(); h = p % HT; v = p / HT;
      if (int'(hcount) != h || int'(vcount) != v) e_cnt++;
      if (hblank_n != (h < HA)) e_hb++;
      if (vblank_n != (v < VA)) e_vb++;
      if (hsync_n != !(h >= HA + HF && h < HA + HF + HS)) e_hs++;
      if (vsync_n != !(v >= VA + VF && v < VA + VF + VS)) e_vs++;
      if (frame_pulse) begin
        n_fp++;
        if (!(v == VA + VF && h == 0)) e_fp++;
      end
      ep = 1'b0;
      if (h < HA && v < VA && !black) begin
        w = pat(b_now + AW'(2 * (v * WPL + h / WW)));
        ep = w[WW - 1 - (h % WW)];
      end
      if (pixel !== ep) e_pix++;
      if (black && h > HA) begin
        nr = (v == VT - 1) ? 0 : v + 1;
        if (nr < VA) begin
          if (!(fetch_valid === 1'b1 && fetch_addr == b_now + AW'(2 * nr * WPL))) e_req++;
        end else if (fetch_valid !== 1'b0) e_req++;
      end
    end
    chk(e_cnt == 0, "R1 R2 counter mismatches", e_cnt, 0);
    chk(e_hb == 0, "R1 hblank mismatches", e_hb, 0);
    chk(e_vb == 0, "R2 vblank mismatches", e_vb, 0);
    chk(e_hs == 0, "R3 hsync mismatches", e_hs, 0);
    chk(e_vs == 0, "R4 vsync mismatches", e_vs, 0);
    chk(n_fp == 1 && e_fp == 0, "R5 frame pulses (count*100+misplaced)",
        n_fp * 100 + e_fp, 100);
    chk(e_pix == 0, black ? "R11 R10 black frame pixel mismatches"
                          : "R9 R10 pixel mismatches", e_pix, 0);
    if (black) begin
      chk(e_req == 0, "R11 R8 posted request mismatches", e_req, 0);
      chk(gn == 0, "R11 grants while stalled", gn, 0);
    end else begin
      chk(gn == VA * WPL, "R7 grant count", gn, VA * WPL);
      for (int i = 0; i < VA * WPL && i < gn && i < 64; i++) begin
        logic [AW-1:0] ea;
        ea = (i < VA * WPL - 1) ? b_now + AW'(2 * (i + 1)) : b_next;
        if (glog[i] != ea) chk(0, "R7 fetch address", int'(glog[i]), int'(ea));
      end
    end
  endtask

  task automatic t_basic();
    mem_on = 1; mem_stall = 0; mem_lat = 1;
    check_frame(24'h9F9A80, 24'h9F9A80, 0);
  endtask

  task automatic t_base_switch();
    check_frame(24'h9F9A80, 24'h012340, 0);
    check_frame(24'h012340, 24'h012340, 0);
  endtask

  task automatic t_slow_memory();
    mem_stall = 1; mem_lat = 7;
    check_frame(24'h012340, 24'h012340, 0);
    mem_stall = 0; mem_lat = 1;
  endtask

  task automatic t_no_grant();
    do begin @(negedge clk); #1; end while (pos() != 2);
    mem_on = 0;
    check_frame(24'h012340, 24'h012340, 1);
    mem_on = 1;
    check_frame(24'h012340, 24'h012340, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_basic();
    t_base_switch();
    t_slow_memory();
    t_no_grant();
    finish_run();
  end

endmodule